// File: doc/BRIEF.md
# I2C Bus Clear Recovery Sequencer

This block frees a two-wire bus when a target has been left mid-byte and is holding SDA low. A one-cycle start request makes the block take over both open-drain lines. It lets both lines float for one half-period and then samples SDA. While SDA still reads low, it clocks SCL one full period at a time, up to a fixed pulse budget. It then drives a STOP condition and hands the lines back to the normal transfer engine.

All timing is measured in half-periods. A half-period is a programmable number of system clocks, so a 5 us half-period gives 100 kHz standard-mode clocking. The two line outputs are pull-down enables: 1 pulls the wire low and 0 lets the pull-up raise it. The SDA input must already be synchronised to the clock. The line that shows ownership tells the pin multiplexer which engine drives the pins.

Top module: `bus_clear_seq`

## Requirements
- R1: During and after reset, before any start, owns_bus_o, scl_oe_o, sda_oe_o, done_o and fail_o are all 0.
- R2: A start_i seen while idle raises owns_bus_o on the next edge. The block then leaves both lines released for one half-period and samples sda_i in the last cycle of that half-period. While owns_bus_o is 0, neither line is pulled.
- R3: A half-period lasts half_period_i clocks. A value of 0 behaves as 1.
- R4: Each SCL pulse is one half-period released (high) followed by one half-period pulled (scl_oe_o=1). sda_i is sampled in the last cycle of every low half. Pulses go on only while that sample is 0, and there are at most MAX_PULSES of them (default 9). If the first sample is already 1, no pulse is issued.
- R5: sda_oe_o stays 0 from the start until the pulse loop ends.
- R6: The STOP is formed in three half-periods in this order. First, SCL and SDA are both pulled for one half-period. Next, SCL is released while SDA stays pulled for one half-period. Finally, SDA is released while SCL is released.
- R7: done_o is high for exactly one clock. That clock is the first cycle in which owns_bus_o is 0 again.
- R8: fail_o becomes 1 only when sda_i still samples 0 after the last allowed pulse. A run that ends early, or whose last sample is 1, leaves fail_o at 0. fail_o holds its value after the run and is cleared when the next start is accepted.
- R9: start_i is ignored while owns_bus_o is 1. The run keeps its length and done_o pulses once.
- R10: A run that issues p pulses keeps owns_bus_o high for (3 + 2p) half-periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a recovery run |
| half_period_i | input | HP_W | Half-period length in clocks (0 acts as 1) |
| sda_i | input | 1 | Synchronised SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| owns_bus_o | output | 1 | Sequencer owns the pins |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | SDA was still low after the last pulse |

## Verification
The bench sweeps the half-period setting, including 0, against a model target that holds SDA low for a chosen number of SCL falls. That number runs from zero up to beyond the pulse budget, so every way the loop can end is covered.

Several faults are targeted directly:
- An off-by-one in the pulse budget shows up in two ways: a ninth-pulse release is flagged as failed, or a tenth pulse is issued.
- A half-period counter that is wrong, or that mishandles a setting of 0, changes the total owned time and the SCL low time.
- A STOP that releases SDA while SCL is still low appears as a bad release edge.
- A block that accepts a second start mid-run stretches the run or pulses done_o twice.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REL,
    ST_HI,
    ST_LO,
    ST_SSET,
    ST_SHOLD
  } bcs_state_e;
endpackage

// File: rtl/bcs_half_timer.sv
module bcs_half_timer #(
  parameter int HP_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [HP_W-1:0] hp_i,
  output logic            expire_o
);
  logic [HP_W-1:0] cnt_q;
  logic [HP_W-1:0] hp_eff;

  // zero length is clamped to a single clock
  assign hp_eff = (hp_i == '0) ? HP_W'(1) : hp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= hp_eff - HP_W'(1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - HP_W'(1);
  end

  assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/bcs_pulse_cnt.sv
module bcs_pulse_cnt #(
  parameter int MAX_PULSES = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CNT_W = $clog2(MAX_PULSES + 1);
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(MAX_PULSES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + CNT_W'(1);
  end

  // high while the pulse in flight is the final one allowed
  assign last_o = (cnt_q == LAST_VAL);
endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic sda_i,
  input  logic expire_i,
  input  logic last_i,
  output logic load_o,
  output logic clr_o,
  output logic inc_o,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic owns_bus_o,
  output logic done_o,
  output logic fail_o
);
  bcs_state_e state_q, state_d;
  logic       done_q, fail_q;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    clr_o   = 1'b0;
    inc_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_REL;
        load_o  = 1'b1;
        clr_o   = 1'b1;
      end
      ST_REL: if (expire_i) begin
        load_o  = 1'b1;
        state_d = sda_i ? ST_SSET : ST_HI;
      end
      ST_HI: if (expire_i) begin
        load_o  = 1'b1;
        state_d = ST_LO;
      end
      ST_LO: if (expire_i) begin
        load_o  = 1'b1;
        inc_o   = 1'b1;
        state_d = (sda_i || last_i) ? ST_SSET : ST_HI;
      end
      ST_SSET: if (expire_i) begin
        load_o  = 1'b1;
        state_d = ST_SHOLD;
      end
      ST_SHOLD: if (expire_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_SHOLD) && expire_i;
      if ((state_q == ST_IDLE) && start_i)
        fail_q <= 1'b0;
      else if ((state_q == ST_LO) && expire_i && last_i && !sda_i)
        fail_q <= 1'b1;
    end
  end

  assign owns_bus_o = (state_q != ST_IDLE);
  assign scl_oe_o   = (state_q == ST_LO) || (state_q == ST_SSET);
  assign sda_oe_o   = (state_q == ST_SSET) || (state_q == ST_SHOLD);
  assign done_o     = done_q;
  assign fail_o     = fail_q;
endmodule

// File: rtl/bus_clear_seq.sv
module bus_clear_seq #(
  parameter int HP_W       = 16,
  parameter int MAX_PULSES = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [HP_W-1:0] half_period_i,
  input  logic            sda_i,
  output logic            scl_oe_o,
  output logic            sda_oe_o,
  output logic            owns_bus_o,
  output logic            done_o,
  output logic            fail_o
);
  logic load, clr, inc, expire, last;

  bcs_half_timer #(.HP_W(HP_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .hp_i     (half_period_i),
    .expire_o (expire)
  );

  bcs_pulse_cnt #(.MAX_PULSES(MAX_PULSES)) u_pcnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .inc_i  (inc),
    .last_o (last)
  );

  bcs_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .sda_i      (sda_i),
    .expire_i   (expire),
    .last_i     (last),
    .load_o     (load),
    .clr_o      (clr),
    .inc_o      (inc),
    .scl_oe_o   (scl_oe_o),
    .sda_oe_o   (sda_oe_o),
    .owns_bus_o (owns_bus_o),
    .done_o     (done_o),
    .fail_o     (fail_o)
  );
endmodule

// File: rtl/bus_clear_seq_chk.sv
module bus_clear_seq_chk #(
  parameter int MAX_PULSES = 9
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic scl_oe_o,
  input logic sda_oe_o,
  input logic owns_bus_o,
  input logic done_o,
  input logic fail_o
);
  localparam int CW = $clog2(MAX_PULSES + 2) + 1;
  logic [CW-1:0] pulses_q;
  logic          scl_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulses_q <= '0;
      scl_d    <= 1'b0;
    end else begin
      scl_d <= scl_oe_o;
      if (!owns_bus_o)                          pulses_q <= '0;
      else if (scl_oe_o && !scl_d && !sda_oe_o) pulses_q <= pulses_q + CW'(1);
    end
  end

  assert_idle_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !owns_bus_o |-> (!scl_oe_o && !sda_oe_o));

  assert_pulse_budget_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulses_q <= CW'(MAX_PULSES));

  assert_stop_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> !scl_oe_o);

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_handback_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (!owns_bus_o && $fell(owns_bus_o)));

  assert_fail_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!owns_bus_o && !start_i) |=> $stable(fail_o));
endmodule

bind bus_clear_seq bus_clear_seq_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .scl_oe_o   (scl_oe_o),
  .sda_oe_o   (sda_oe_o),
  .owns_bus_o (owns_bus_o),
  .done_o     (done_o),
  .fail_o     (fail_o)
);

// File: tb/sim_bus_clear_seq.sv
`timescale 1ns/1ps
module sim_bus_clear_seq;
  localparam int HP_W = 16;
  localparam int MAXP = 9;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [HP_W-1:0] half_period = '0;
  logic sda_i;
  logic scl_oe, sda_oe, owns, done, fail;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // target model: holds SDA low until it has seen target_n SCL falls
  int target_n = 0;
  int falls = 0;
  int pulses = 0, owned = 0, done_cnt = 0, lo_cyc = 0, sda_cyc = 0;
  int stop_seen = 0, stop_bad = 0;
  logic scl_d = 1'b0, sda_d = 1'b0;

  always #4 clk = ~clk;

  assign sda_i = !(sda_oe || (falls < target_n));

  bus_clear_seq #(.HP_W(HP_W), .MAX_PULSES(MAXP)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .half_period_i(half_period), .sda_i(sda_i),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .owns_bus_o(owns),
    .done_o(done), .fail_o(fail)
  );

  always @(negedge clk) begin
    if (scl_oe && !scl_d && !sda_oe) begin
      falls  <= falls + 1;
      pulses <= pulses + 1;
    end
    if (owns) owned <= owned + 1;
    if (done) done_cnt <= done_cnt + 1;
    if (scl_oe && !sda_oe) lo_cyc <= lo_cyc + 1;
    if (sda_oe) sda_cyc <= sda_cyc + 1;
    if (sda_d && !sda_oe) begin
      stop_seen <= stop_seen + 1;
      if (scl_oe) stop_bad <= stop_bad + 1;
    end
    scl_d <= scl_oe;
    sda_d <= sda_oe;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (hp=%0d n=%0d)",
               req, act, exp, half_period, target_n);
    end
  endtask

  task automatic run(input int hp, input int n);
    int h, p, guard;
    h = (hp == 0) ? 1 : hp;
    p = (n < MAXP) ? n : MAXP;
    @(posedge clk);
    half_period = HP_W'(hp);
    target_n = n;
    falls = 0; pulses = 0; owned = 0; done_cnt = 0;
    lo_cyc = 0; sda_cyc = 0; stop_seen = 0; stop_bad = 0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    @(negedge clk) start_i = 1'b1;   // R9: ignored mid-run
    @(negedge clk) start_i = 1'b0;
    guard = 0;
    while (done_cnt == 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);
    check("R4 pulse count", pulses, p);
    check("R3/R4 scl low time", lo_cyc, p * h);
    check("R8 fail flag", int'(fail), (n > MAXP) ? 1 : 0);
    check("R10 owned time", owned, (3 + 2 * p) * h);
    check("R9/R7 done pulses", done_cnt, 1);
    check("R6 stop release", stop_seen * 10 + stop_bad, 10);
    check("R5/R6 sda pull time", sda_cyc, 2 * h);
    check("R2 handback", int'(owns) + int'(scl_oe) + int'(sda_oe), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs",
          int'(owns) + int'(scl_oe) + int'(sda_oe) + int'(done) + int'(fail), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset",
          int'(owns) + int'(scl_oe) + int'(sda_oe) + int'(done) + int'(fail), 0);
    for (int hp = 0; hp <= 4; hp++)
      for (int n = 0; n <= 11; n++)
        run(hp, n);
    // R8: a fail is cleared by the next successful run
    run(2, 12);
    run(2, 3);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule